// File: doc/BRIEF.md
# Level-Mapped System Interrupt Controller

This block gathers eight level-sensitive device request lines and presents them to a processor as sixteen interrupt-priority-level lines, one line per level. A fixed, sparse table ties each request line to a level: line 1 to level 1, line 2 to level 4, line 3 to level 6, line 4 to level 8, line 5 to level 10 and line 7 to level 14. Lines 0 and 6 map to level 0, which means "no interrupt", so they are dead inputs. When more than one live request is high, all of the matching level outputs are high together. The block does not encode the sixteen lines into a level number.

A single 8-bit control register sits behind a byte-wide port with a valid strobe and a write-enable strobe. The port answers with no wait states. Bit 0 of the register enables every output. Bit 6 cannot be set: the block clears it on every write. Requests pass through a two-flop synchroniser and then into a pending register that follows the line levels. The output vector is registered. It is recomputed from the pending bits and the enable bit in every cycle, so it responds both to register writes and to input changes.

Top module: `lvl_irq_ctl`

## Requirements
- R1: After reset the control register reads 0x01, and all sixteen level outputs are low.
- R2: `bus_rdata` shows the stored control register at all times, with no wait state.
- R3: A cycle with `bus_valid` and `bus_we` both high stores `bus_wdata & 8'hBF`, so the stored bit 6 is always 0. The new value can be read after the next clock edge.
- R4: While the block is enabled, output bit `lvl_o[L]` is high exactly when a held request line maps to level L. The table is: req 1→L1, req 2→L4, req 3→L6, req 4→L8, req 5→L10, req 7→L14.
- R5: Request lines 0 and 6 have no effect, and output bits 0, 2, 3, 5, 7, 9, 11, 12, 13 and 15 are never high.
- R6: Requests are level-sensitive. When a request line goes low, its level output falls again, and nothing is held.
- R7: Several live requests held together drive their distinct level outputs at the same time.
- R8: While control bit 0 is 0, all outputs are low in the cycle after the control value is seen. Pending bits keep following the inputs, so the outputs show the current requests one clock edge after a write that sets bit 0 again.
- R9: A request change reaches `lvl_o` on the fourth rising edge after it is applied: two synchroniser flops, the pending flop and the output flop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Level-sensitive device request lines, asynchronous |
| bus_valid | input | 1 | Register access strobe |
| bus_we | input | 1 | Write enable, qualified by bus_valid |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Control register contents |
| lvl_o | output | 16 | One line per processor priority level |

## Verification
The bench builds the block with its default parameters: two synchroniser stages, the sparse level table and a reset control value of 0x01. With these defaults the exact four-edge input latency and the single-edge write latency can be counted and checked cycle by cycle. Random request patterns and random control writes cover every mix of live and dead lines together with both states of the enable bit. Directed cases cover the dead lines, the clearing of bit 6 and re-enabling while requests are still held.

// File: rtl/lvl_irq_ctl.sv
module lvl_irq_ctl #(
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  RESET_CTRL  = 8'h01,
  parameter logic [7:0]  WRITE_MASK  = 8'hBF,
  parameter logic [31:0] LVL_TABLE   = {4'd14, 4'd0, 4'd10, 4'd8, 4'd6, 4'd4, 4'd1, 4'd0}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  req_i,
  input  logic        bus_valid,
  input  logic        bus_we,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic [15:0] lvl_o
);

  localparam int NLINES = 8;
  localparam int NLVL   = 16;

  logic [SYNC_STAGES-1:0][NLINES-1:0] sync_q;
  logic [NLINES-1:0] live_mask;
  logic [NLINES-1:0] pend_q;
  logic [7:0]        ctrl_q;
  logic [NLVL-1:0]   lvl_next;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q[0] <= '0;
    else        sync_q[0] <= req_i;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n) sync_q[s] <= '0;
      else        sync_q[s] <= sync_q[s-1];
    end
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_live
    assign live_mask[i] = (LVL_TABLE[4*i +: 4] != 4'd0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= sync_q[SYNC_STAGES-1] & live_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   ctrl_q <= RESET_CTRL;
    else if (bus_valid && bus_we) ctrl_q <= bus_wdata & WRITE_MASK;
  end

  assign bus_rdata = ctrl_q;

  always_comb begin
    lvl_next = '0;
    for (int i = 0; i < NLINES; i++)
      if (pend_q[i]) lvl_next[LVL_TABLE[4*i +: 4]] = 1'b1;
    lvl_next[0] = 1'b0;
    if (!ctrl_q[0]) lvl_next = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_o <= '0;
    else        lvl_o <= lvl_next;
  end

endmodule

module lvl_irq_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_valid,
  input logic        bus_we,
  input logic [7:0]  bus_wdata,
  input logic [7:0]  bus_rdata,
  input logic [15:0] lvl_o
);

  p_write_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_we) |=> bus_rdata == ($past(bus_wdata) & 8'hBF));

  p_bit6_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[6] == 1'b0);

  p_dead_levels_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_o & ~16'h4552) == 16'h0);

  p_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rdata[0] |=> lvl_o == 16'h0);

endmodule

bind lvl_irq_ctl lvl_irq_ctl_chk u_chk (.*);

// File: tb/test_lvl_irq_ctl.sv
`timescale 1ns/1ps
module test_lvl_irq_ctl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  req_i = 0;
  logic        bus_valid = 0;
  logic        bus_we = 0;
  logic [7:0]  bus_wdata = 0;
  logic [7:0]  bus_rdata;
  logic [15:0] lvl_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lvl_irq_ctl i_lvl_irq_ctl (.*);

  function automatic logic [15:0] exp_lvl(input logic [7:0] r, input logic [7:0] c);
    int lv [8] = '{0, 1, 4, 6, 8, 10, 0, 14};
    logic [15:0] v = '0;
    if (!c[0]) return '0;
    for (int i = 0; i < 8; i++)
      if (r[i] && lv[i] != 0) v[lv[i]] = 1'b1;
    return v;
  endfunction

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    bus_valid = 1; bus_we = 1; bus_wdata = d;
    step();
    bus_valid = 0; bus_we = 0; bus_wdata = $urandom;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] ctrl;
    void'($urandom(32'd1234));
    step(3);
    rst_n = 1;
    #0.1;
    chk("R1 ctrl", {8'h0, bus_rdata}, 16'h0001);
    chk("R1 lvl", lvl_o, 16'h0);
    ctrl = 8'h01;

    // R4 single lines; R5 dead lines 0 and 6
    for (int i = 0; i < 8; i++) begin
      req_i = 8'(1 << i);
      step(4);
      chk(i == 0 || i == 6 ? "R5 dead line" : "R4 map", lvl_o, exp_lvl(req_i, ctrl));
    end
    req_i = 8'h41; step(4);
    chk("R5 both dead", lvl_o, 16'h0);

    // R6 release
    req_i = 8'h04; step(4);
    chk("R6 set", lvl_o, 16'h0010);
    req_i = 8'h00; step(4);
    chk("R6 clear", lvl_o, 16'h0);

    // R7 simultaneous
    req_i = 8'hBE; step(4);
    chk("R7 all live", lvl_o, 16'h4552);
    req_i = 8'hFF; step(4);
    chk("R7 all lines", lvl_o, 16'h4552);

    // R9 latency
    req_i = 8'h00; step(5);
    req_i = 8'h80; step(3);
    chk("R9 before 4th edge", lvl_o, 16'h0);
    step();
    chk("R9 at 4th edge", lvl_o, 16'h4000);

    // R3 / R2 write masking
    wr(8'hFF); ctrl = 8'hBF;
    chk("R3 store ff", {8'h0, bus_rdata}, 16'h00BF);
    wr(8'h40); ctrl = 8'h00;
    chk("R3 bit6 only", {8'h0, bus_rdata}, 16'h0000);
    step();
    chk("R8 disabled", lvl_o, 16'h0);
    chk("R2 read stable", {8'h0, bus_rdata}, 16'h0000);
    bus_valid = 1; bus_we = 0; bus_wdata = 8'h01; step();
    bus_valid = 0;
    chk("R2 read no write", {8'h0, bus_rdata}, 16'h0000);

    // R8 pending tracks while disabled
    req_i = 8'h22; step(6);
    chk("R8 still off", lvl_o, 16'h0);
    wr(8'h01); ctrl = 8'h01;
    chk("R8 write edge", lvl_o, 16'h0);
    step();
    chk("R8 reenable", lvl_o, 16'h0402);

    // random
    for (int n = 0; n < 300; n++) begin
      req_i = $urandom;
      if ($urandom_range(0, 2) == 0) begin
        logic [7:0] d = $urandom;
        wr(d); ctrl = d & 8'hBF;
        chk("R3 random write", {8'h0, bus_rdata}, {8'h0, ctrl});
      end
      step(4);
      chk(ctrl[0] ? "R4 random" : "R8 random", lvl_o, exp_lvl(req_i, ctrl));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule